// File: doc/BRIEF.md
# DMA Stream FIFO Control Unit

This block is the FIFO control and status logic of one DMA stream. It holds a small byte FIFO and tracks how full it is. The fill level is reported in a 3-bit status code made of quarter bands plus separate codes for empty and full. A drain request is raised once the level reaches a flush point chosen by software. The same control register holds the flush-point field, a FIFO-mode (direct-mode-disable) bit and an error interrupt enable.

The threshold and FIFO-mode fields are locked while the stream is enabled. When the stream runs in memory-to-memory direction, hardware forces FIFO mode on, because direct mode cannot be used for that transfer type. In FIFO mode, a push into a full FIFO or a pop from an empty one sets a sticky error flag. That flag, gated by the enable bit, drives the interrupt output. Software clears the flag by writing a one.

Top module: `dma_fifo_ctrl`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 8'h21 (status code 100 for empty, threshold 01, FIFO-mode 0, interrupt enable 0), and both `err_irq` and `drain_req` are 0.
- R2: Bits 5:3 of `reg_rdata` show the fill code for the 16-entry FIFO: 100 when empty, 101 when full, 000 for 1–3 bytes, 001 for 4–7, 010 for 8–11 and 011 for 12–15. These bits are read-only.
- R3: Bit 7 is the error interrupt enable. A register write always updates it, whatever the stream state. Bit 6 always reads 0.
- R4: Bits 1:0 (threshold) and bit 2 (FIFO-mode, 1 = FIFO mode, 0 = direct mode) take the written value only when `stream_en` is 0. A write while `stream_en` is 1 leaves them unchanged.
- R5: While `stream_en` is 1 and `xfer_dir` is 2'b10, bit 2 is set to 1 at the next clock edge. It stays 1 until software writes it with the stream disabled.
- R6: `drain_req` is 1 exactly when the fill level is at least 4, 8, 12 or 16 bytes, for threshold codes 00, 01, 10 and 11 respectively.
- R7: The FIFO is first-in first-out, and `pop_data` shows the oldest byte. A push while full is dropped, and a pop while empty changes nothing. A simultaneous push and pop is accepted when the FIFO is neither empty nor full.
- R8: In FIFO mode (bit 2 = 1), a push while full or a pop while empty sets the error flag. In direct mode neither case sets it.
- R9: `err_irq` equals the error flag ANDed with bit 7. A write with bit 6 = 1 clears the flag, but an error in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| stream_en | input | 1 | Stream enable |
| xfer_dir | input | 2 | Transfer direction, 2'b10 = memory to memory |
| push | input | 1 | Push a byte into the FIFO |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop the oldest byte |
| pop_data | output | 8 | Oldest byte in the FIFO |
| drain_req | output | 1 | Fill level has reached the flush point |
| err_irq | output | 1 | FIFO error interrupt |

## Verification
The bench builds the block with its default 16-byte depth and 8-bit data. At that size, overflow and underflow each take at most 17 operations. Every fill band and all four flush points are reached within a single fill and drain. Directed phases exercise write locking, forced FIFO mode and error clearing. A long randomized phase then mixes pushes, pops, register writes and stream states, and a queue-based reference model checks every output field on each cycle.

// File: rtl/dma_fifo_pkg.sv
`timescale 1ns/1ps
package dma_fifo_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_IE    = 7;
    localparam int BIT_W1C   = 6;
    localparam int BIT_FMODE = 2;

    localparam logic [1:0] DIR_MEM2MEM = 2'b10;

    typedef enum logic [2:0] {
        FC_BELOW_Q1   = 3'b000,
        FC_BELOW_HALF = 3'b001,
        FC_BELOW_Q3   = 3'b010,
        FC_BELOW_FULL = 3'b011,
        FC_EMPTY      = 3'b100,
        FC_FULL       = 3'b101
    } fill_code_e;

    typedef enum logic [1:0] {
        FP_QUARTER = 2'b00,
        FP_HALF    = 2'b01,
        FP_3QUART  = 2'b10,
        FP_FULL    = 2'b11
    } flush_pt_e;

    typedef struct packed {
        logic      err_ie;
        logic      fifo_mode;
        flush_pt_e flush_pt;
    } cfg_t;

    function automatic fill_code_e fill_code(int unsigned lvl, int unsigned depth);
        if (lvl == 0)              return FC_EMPTY;
        if (lvl >= depth)          return FC_FULL;
        if (lvl * 4 < depth)       return FC_BELOW_Q1;
        if (lvl * 2 < depth)       return FC_BELOW_HALF;
        if (lvl * 4 < depth * 3)   return FC_BELOW_Q3;
        return FC_BELOW_FULL;
    endfunction

    function automatic int unsigned flush_bytes(flush_pt_e pt, int unsigned depth);
        case (pt)
            FP_QUARTER: return depth / 4;
            FP_HALF:    return depth / 2;
            FP_3QUART:  return (depth * 3) / 4;
            default:    return depth;
        endcase
    endfunction

endpackage

// File: rtl/dma_fifo_store.sv
`timescale 1ns/1ps
module dma_fifo_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [LW-1:0]     level,
    output logic              push_ovf,
    output logic              pop_unf
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              is_full, is_empty, do_push, do_pop;

    assign is_full  = (level == FULL_LVL);
    assign is_empty = (level == '0);
    assign do_push  = push && !is_full;
    assign do_pop   = pop && !is_empty;
    assign push_ovf = push && is_full;
    assign pop_unf  = pop && is_empty;
    assign head_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/dma_fifo_level_dec.sv
`timescale 1ns/1ps
module dma_fifo_level_dec
    import dma_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] level,
    input  flush_pt_e     flush_pt,
    output fill_code_e    code,
    output logic          drain_req
);
    always_comb begin
        code      = fill_code(int'(level), DEPTH);
        drain_req = int'(level) >= int'(flush_bytes(flush_pt, DEPTH));
    end
endmodule

// File: rtl/dma_fifo_cfg_regs.sv
`timescale 1ns/1ps
module dma_fifo_cfg_regs
    import dma_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             stream_en,
    input  logic [1:0]       dir,
    input  logic             err_evt,
    output cfg_t             cfg,
    output logic             err_flag
);
    logic force_fifo;
    assign force_fifo = stream_en && (dir == DIR_MEM2MEM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.err_ie    <= 1'b0;
            cfg.fifo_mode <= 1'b0;
            cfg.flush_pt  <= FP_HALF;
            err_flag      <= 1'b0;
        end else begin
            if (wr_en) cfg.err_ie <= wdata[BIT_IE];
            if (wr_en && !stream_en) begin
                cfg.flush_pt  <= flush_pt_e'(wdata[1:0]);
                cfg.fifo_mode <= wdata[BIT_FMODE];
            end
            if (force_fifo) cfg.fifo_mode <= 1'b1;
            if (err_evt)
                err_flag <= 1'b1;
            else if (wr_en && wdata[BIT_W1C])
                err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_fifo_ctrl.sv
`timescale 1ns/1ps
module dma_fifo_ctrl
    import dma_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              stream_en,
    input  logic [1:0]        xfer_dir,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              drain_req,
    output logic              err_irq
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level;
    logic          push_ovf, pop_unf, err_evt, err_flag;
    cfg_t          cfg;
    fill_code_e    code;

    dma_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .head_data(pop_data), .level(level), .push_ovf(push_ovf), .pop_unf(pop_unf)
    );

    dma_fifo_level_dec #(.DEPTH(DEPTH)) u_dec (
        .level(level), .flush_pt(cfg.flush_pt), .code(code), .drain_req(drain_req)
    );

    assign err_evt = cfg.fifo_mode && (push_ovf || pop_unf);

    dma_fifo_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wdata(reg_wdata),
        .stream_en(stream_en), .dir(xfer_dir), .err_evt(err_evt),
        .cfg(cfg), .err_flag(err_flag)
    );

    assign err_irq   = err_flag && cfg.err_ie;
    assign reg_rdata = {cfg.err_ie, 1'b0, code, cfg.fifo_mode, cfg.flush_pt};
endmodule

// File: rtl/dma_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module dma_fifo_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       stream_en,
    input logic [1:0] xfer_dir,
    input logic       push,
    input logic       pop,
    input logic       drain_req,
    input logic       err_irq
);
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:3] <= 3'b101); // R2
    AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6] == 1'b0); // R3
    AST_THRESH_LOCKED: assert property (@(posedge clk) disable iff (rst)
        stream_en |=> $stable(reg_rdata[1:0])); // R4
    AST_FMODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (stream_en && xfer_dir != 2'b10) |=> $stable(reg_rdata[2])); // R4
    AST_M2M_FORCE: assert property (@(posedge clk) disable iff (rst)
        (stream_en && xfer_dir == 2'b10) |=> reg_rdata[2]); // R5
    AST_FULL_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[5:3] == 3'b101) |-> drain_req); // R6
    AST_EMPTY_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[5:3] == 3'b100) |-> !drain_req); // R6
    AST_OVF_ERR: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] && reg_rdata[2] && push && !reg_wr && reg_rdata[5:3] == 3'b101) |=> err_irq); // R8
    AST_UNF_ERR: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] && reg_rdata[2] && pop && !reg_wr && reg_rdata[5:3] == 3'b100) |=> err_irq); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> reg_rdata[7]); // R9
endmodule

bind dma_fifo_ctrl dma_fifo_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .stream_en(stream_en), .xfer_dir(xfer_dir), .push(push), .pop(pop),
    .drain_req(drain_req), .err_irq(err_irq)
);

// File: tb/dma_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module dma_fifo_ctrl_bench;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stream_en = 1'b0;
    logic [1:0] xfer_dir = '0;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       drain_req, err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] q[$];
    bit m_ie = 0, m_fm = 0, m_flag = 0;
    logic [1:0] m_thr = 2'b01;

    always #5 clk = ~clk;

    dma_fifo_ctrl u_dma_fifo_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stream_en(stream_en), .xfer_dir(xfer_dir),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .drain_req(drain_req), .err_irq(err_irq)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_code(int n);
        if (n == 0) return 3'b100;
        if (n == DEPTH) return 3'b101;
        if (n < 4) return 3'b000;
        if (n < 8) return 3'b001;
        if (n < 12) return 3'b010;
        return 3'b011;
    endfunction

    function automatic int flush_at(logic [1:0] t);
        case (t)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic compare_all();
        int n = q.size();
        check(reg_rdata[5:3] == exp_code(n), "R2 fill code", int'(reg_rdata[5:3]), int'(exp_code(n)));
        check(reg_rdata[7] == m_ie && reg_rdata[6] == 1'b0, "R3 ie/bit6", int'(reg_rdata[7:6]), int'({m_ie, 1'b0}));
        check(reg_rdata[1:0] == m_thr, "R4 threshold", int'(reg_rdata[1:0]), int'(m_thr));
        check(reg_rdata[2] == m_fm, "R5 fifo-mode", int'(reg_rdata[2]), int'(m_fm));
        check(drain_req == (n >= flush_at(m_thr)), "R6 drain", int'(drain_req), int'(n >= flush_at(m_thr)));
        if (n > 0)
            check(pop_data == q[0], "R7 head", int'(pop_data), int'(q[0]));
        check(err_irq == (m_flag && m_ie), "R9 irq", int'(err_irq), int'(m_flag && m_ie));
    endtask

    task automatic step(bit wr, logic [7:0] wd, bit en, logic [1:0] dir,
                        bit ps, logic [7:0] pd, bit pp);
        int n;
        bit err;
        reg_wr = wr; reg_wdata = wd; stream_en = en; xfer_dir = dir;
        push = ps; push_data = pd; pop = pp;
        @(posedge clk);
        n = q.size();
        err = m_fm && ((ps && n == DEPTH) || (pp && n == 0));
        if (pp && n > 0) void'(q.pop_front());
        if (ps && n < DEPTH) q.push_back(pd);
        if (err) m_flag = 1;
        else if (wr && wd[6]) m_flag = 0;
        if (wr) m_ie = wd[7];
        if (wr && !en) begin m_thr = wd[1:0]; m_fm = wd[2]; end
        if (en && dir == 2'b10) m_fm = 1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); step(0, 8'h00, 0, 2'b00, 0, 8'h00, 0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 8'h21, "R1 reset rdata", int'(reg_rdata), 8'h21);
        check(!err_irq && !drain_req, "R1 reset outputs", int'({err_irq, drain_req}), 0);

        // FIFO mode, ie=1, threshold 3/4
        step(1, 8'h86, 0, 2'b00, 0, 8'h00, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 2'b00, 1, 8'(8'h30 + i), 0);
        // R8 overflow in FIFO mode
        step(0, 8'h00, 0, 2'b00, 1, 8'hEE, 0);
        check(err_irq == 1'b1, "R8 overflow error", int'(err_irq), 1);
        // R9 clear, and set-wins case
        step(1, 8'hC6, 0, 2'b00, 1, 8'hEE, 0);
        check(err_irq == 1'b1, "R9 set wins over clear", int'(err_irq), 1);
        step(1, 8'hC6, 0, 2'b00, 0, 8'h00, 0);
        check(err_irq == 1'b0, "R9 w1c clear", int'(err_irq), 0);
        // thresholds swept while full then draining
        for (int t = 0; t < 4; t++) step(1, 8'(8'h84 | t), 0, 2'b00, 0, 8'h00, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 2'b00, 0, 8'h00, 1);
        step(0, 8'h00, 0, 2'b00, 0, 8'h00, 1);
        check(err_irq == 1'b1, "R8 underflow error", int'(err_irq), 1);
        step(1, 8'hC4, 0, 2'b00, 0, 8'h00, 0);

        // R4 locked while enabled; ie still writable (R3)
        step(1, 8'h03, 1, 2'b00, 0, 8'h00, 0);
        check(reg_rdata[1:0] == 2'b00 && reg_rdata[2] && !reg_rdata[7], "R4 locked write", int'(reg_rdata), 8'h24);
        // R5 forcing: clear fifo-mode, then enable memory-to-memory
        step(1, 8'h01, 0, 2'b00, 0, 8'h00, 0);
        step(0, 8'h00, 1, 2'b10, 0, 8'h00, 0);
        check(reg_rdata[2] == 1'b1, "R5 forced fifo mode", int'(reg_rdata[2]), 1);
        step(1, 8'h80, 1, 2'b10, 0, 8'h00, 0);
        check(reg_rdata[2] == 1'b1, "R5 stays forced", int'(reg_rdata[2]), 1);

        // direct mode: no errors (R8)
        step(1, 8'h81, 0, 2'b00, 0, 8'h00, 0);
        step(1, 8'h81, 0, 2'b00, 0, 8'h00, 1);
        check(err_irq == 1'b0, "R8 direct mode no error", int'(err_irq), 0);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 0, 2'b01, 1, 8'(i * 7), 0);
        check(err_irq == 1'b0, "R8 direct overflow no error", int'(err_irq), 0);
        // R7 push and pop together while full: push dropped
        step(0, 8'h00, 0, 2'b00, 1, 8'hAB, 1);
        step(0, 8'h00, 0, 2'b00, 1, 8'hCD, 1);
        check(q.size() == DEPTH - 1 || reg_rdata[5:3] == exp_code(q.size()), "R7 simultaneous", int'(reg_rdata[5:3]), int'(exp_code(q.size())));

        // randomized mix
        for (int i = 0; i < 3000; i++) begin
            bit wr = ($urandom % 8) == 0;
            bit en = ($urandom % 3) == 0;
            step(wr, 8'($urandom), en, 2'($urandom), ($urandom % 2) == 0,
                 8'($urandom), ($urandom % 2) == 0);
        end
        repeat (2) idle();
        finish_run();
    end
endmodule